// File: doc/BRIEF.md
# Bus Capture Trigger Sequencer

This block decides, one bus sample at a time, whether a bus-capture logic analyzer keeps that sample. It watches the sampled request-type code, address and response lines of a processor bus, together with a strobe that marks a valid sample. A fixed sequence of seven levels picks out I/O writes to one port and keeps the response traffic that follows each one. When a valid sample qualifies, the block raises a store strobe in the same cycle. It also reports the active level and a count of the port writes it has found.

A global default storing rule sets the baseline. The rule is either nothing, every valid sample, or samples flagged by an external custom qualifier. Whatever the default, the active level can still ask for a store on any cycle. After a write is found, a four-way branch chooses the path, and four response-watching levels follow in a chain. A tail level then keeps a fixed number of extra samples and sends the sequencer back to the search.

Top module: `bus_trig_seq`

## Requirements
- R1: After reset the level is 1, the default rule is nothing, the match count is 0, and a valid non-matching sample at level 1 is not stored.
- R2: The default rule is a register loaded from `mode_in` on a cycle with `mode_we` high, and it takes effect from the next cycle. The encoding is 0 = nothing, 1 = every valid sample, 2 = custom qualifier, and 3 behaves as nothing. Under the nothing rule, a sample is stored only when the active level asks for it.
- R3: Under the every-sample rule, each valid sample is stored. Under the custom rule, a valid sample is stored when `cust_qual` is high or when the level asks for it.
- R4: `store_en` depends combinationally on the current sample and is never high in a cycle where `smp_valid` is low.
- R5: At level 1, a valid sample with type equal to `IOWR_CODE` (default 4'h6) and address equal to `PORT_ADDR` (default 16'h0080) is stored, adds one to the match count, and moves the sequencer to level 2. Any other sample leaves the level unchanged and is not stored.
- R6: Level 2 never stores and checks four conditions, in this priority order: (0) response lines non-zero moves to level 4; (1) an I/O write to the port moves to level 3; (2) type `ABORT_CODE` (default 4'hF) moves to level 1; (3) type `DEFER_CODE` (default 4'hE) moves to level 7. If none of them holds, the sequencer stays at level 2.
- R7: At levels 3 to 6, a valid sample with all response lines zero is stored and the level holds. A valid sample with any response line set is not stored, and the sequencer moves to the next level (from 6 it moves to 7).
- R8: Level 7 stores `POST_N` valid samples (default 5). The valid sample that completes this count moves the sequencer to level 1.
- R9: The match count is 16 bits wide, stops at 16'hFFFF, and is cleared only by reset.
- R10: A cycle with `smp_valid` low changes neither the level, nor the tail progress, nor the match count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Load strobe for the default storing rule |
| mode_in | input | 2 | New default rule (0 nothing, 1 all, 2 custom) |
| smp_valid | input | 1 | The current sample is valid |
| smp_type | input | TYPE_W | Sampled request-type code |
| smp_addr | input | ADDR_W | Sampled address |
| smp_resp | input | RESP_W | Sampled response lines |
| cust_qual | input | 1 | External custom storage qualifier |
| store_en | output | 1 | Store the current sample |
| level_o | output | 3 | Active sequence level, 1 to 7 |
| match_cnt | output | CNT_W | Saturating count of level-1 matches |

## Verification
A wrong level shows up at the ports at the next clock edge through `level_o`. It also shows up in the same cycle through `store_en`, because every level has its own storing rule that can be seen in the next valid sample. If the tail counter drifts, the sequencer returns to level 1 one or more samples early or late, which the bench detects within five valid samples. A counter fault is visible on `match_cnt` one cycle after the match that exposes it. The saturation fault appears once the count reaches its maximum.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [2:0] {
    LV_HUNT   = 3'd1,
    LV_BRANCH = 3'd2,
    LV_RSP0   = 3'd3,
    LV_RSP1   = 3'd4,
    LV_RSP2   = 3'd5,
    LV_RSP3   = 3'd6,
    LV_TAIL   = 3'd7
  } level_e;

  typedef enum logic [1:0] {
    DM_NONE = 2'd0,
    DM_ALL  = 2'd1,
    DM_CUST = 2'd2,
    DM_RSVD = 2'd3
  } dmode_e;

  // Fixed-priority branch target: lowest-numbered hit wins.
  function automatic level_e branch_target(input logic [3:0] hits);
    level_e t;
    t = LV_BRANCH;
    if (hits[0])      t = LV_RSP1;
    else if (hits[1]) t = LV_RSP0;
    else if (hits[2]) t = LV_HUNT;
    else if (hits[3]) t = LV_TAIL;
    return t;
  endfunction

  // Step to the following level in the response-watch chain.
  function automatic level_e next_level(input level_e cur);
    level_e t;
    case (cur)
      LV_RSP0: t = LV_RSP1;
      LV_RSP1: t = LV_RSP2;
      LV_RSP2: t = LV_RSP3;
      default: t = LV_TAIL;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/bts_match.sv
module bts_match #(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 16,
  parameter int RESP_W = 3,
  parameter logic [TYPE_W-1:0] IOWR_CODE  = 4'h6,
  parameter logic [TYPE_W-1:0] ABORT_CODE = 4'hF,
  parameter logic [TYPE_W-1:0] DEFER_CODE = 4'hE,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'h0080
) (
  input  logic [TYPE_W-1:0] smp_type,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [RESP_W-1:0] smp_resp,
  output logic              port_wr,
  output logic              resp_any,
  output logic [3:0]        br_hit
);
  localparam int NBR = 4;

  logic [TYPE_W-1:0] br_code [NBR];

  assign port_wr  = (smp_type == IOWR_CODE) && (smp_addr == PORT_ADDR);
  assign resp_any = |smp_resp;

  assign br_code[0] = '0;
  assign br_code[1] = '0;
  assign br_code[2] = ABORT_CODE;
  assign br_code[3] = DEFER_CODE;

  genvar gi;
  generate
    for (gi = 0; gi < NBR; gi++) begin : g_br
      if (gi == 0) begin : g_rsp
        assign br_hit[gi] = resp_any;
      end else if (gi == 1) begin : g_wr
        assign br_hit[gi] = port_wr;
      end else begin : g_code
        assign br_hit[gi] = (smp_type == br_code[gi]);
      end
    end
  endgenerate

endmodule

// File: rtl/bts_level_fsm.sv
module bts_level_fsm
  import bts_pkg::*;
#(
  parameter int POST_N = 5,
  localparam int PC_W = (POST_N < 2) ? 1 : $clog2(POST_N)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic       port_wr,
  input  logic       resp_any,
  input  logic [3:0] br_hit,
  output level_e     level,
  output logic       lvl_store,
  output logic       match_ev
);
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(POST_N - 1);

  level_e          lvl_nxt;
  logic [PC_W-1:0] post_cnt, post_nxt;
  logic            tail_done;

  assign tail_done = (post_cnt == PC_LAST);

  always_comb begin
    lvl_nxt   = level;
    post_nxt  = post_cnt;
    lvl_store = 1'b0;
    match_ev  = 1'b0;
    if (smp_valid) begin
      case (level)
        LV_HUNT: if (port_wr) begin
          lvl_store = 1'b1;
          match_ev  = 1'b1;
          lvl_nxt   = LV_BRANCH;
        end
        LV_BRANCH: lvl_nxt = branch_target(br_hit);
        LV_RSP0, LV_RSP1, LV_RSP2, LV_RSP3: begin
          if (resp_any) lvl_nxt = next_level(level);
          else          lvl_store = 1'b1;
        end
        LV_TAIL: begin
          lvl_store = 1'b1;
          if (tail_done) begin
            post_nxt = '0;
            lvl_nxt  = LV_HUNT;
          end else begin
            post_nxt = post_cnt + 1'b1;
          end
        end
        default: lvl_nxt = LV_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= LV_HUNT;
      post_cnt <= '0;
    end else begin
      level    <= lvl_nxt;
      post_cnt <= post_nxt;
    end
  end

  p_tail_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    post_cnt <= PC_LAST);
  p_tail_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (level != LV_TAIL) |-> (post_cnt == '0));
  p_hunt_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LV_HUNT && smp_valid && port_wr) |=> (level == LV_BRANCH));
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(level) && $stable(post_cnt)));
  p_branch_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LV_BRANCH) |-> !lvl_store);
  p_rsp_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LV_RSP3 && smp_valid && resp_any) |=> (level == LV_TAIL));

endmodule

// File: rtl/bts_store_qual.sv
module bts_store_qual
  import bts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_in,
  input  logic       smp_valid,
  input  logic       lvl_store,
  input  logic       cust_qual,
  output logic       store_en
);
  dmode_e mode_q;
  logic   dflt_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= DM_NONE;
    else if (mode_we) mode_q <= dmode_e'(mode_in);
  end

  always_comb begin
    case (mode_q)
      DM_ALL:  dflt_hit = 1'b1;
      DM_CUST: dflt_hit = cust_qual;
      default: dflt_hit = 1'b0;
    endcase
  end

  assign store_en = smp_valid && (lvl_store || dflt_hit);

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |-> smp_valid);
  p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == DM_NONE || mode_q == DM_RSVD) && !lvl_store) |-> !store_en);
  p_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DM_ALL && smp_valid) |-> store_en);

endmodule

// File: rtl/bts_match_ctr.sv
module bts_match_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= sat_add(cnt);
  end

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == CNT_MAX));
  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/bus_trig_seq.sv
module bus_trig_seq
  import bts_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 16,
  parameter int RESP_W = 3,
  parameter int CNT_W  = 16,
  parameter int POST_N = 5,
  parameter logic [TYPE_W-1:0] IOWR_CODE  = 4'h6,
  parameter logic [TYPE_W-1:0] ABORT_CODE = 4'hF,
  parameter logic [TYPE_W-1:0] DEFER_CODE = 4'hE,
  parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [1:0]        mode_in,
  input  logic              smp_valid,
  input  logic [TYPE_W-1:0] smp_type,
  input  logic [ADDR_W-1:0] smp_addr,
  input  logic [RESP_W-1:0] smp_resp,
  input  logic              cust_qual,
  output logic              store_en,
  output logic [2:0]        level_o,
  output logic [CNT_W-1:0]  match_cnt
);
  logic       port_wr, resp_any, lvl_store, match_ev;
  logic [3:0] br_hit;
  level_e     level;

  bts_match #(
    .TYPE_W(TYPE_W), .ADDR_W(ADDR_W), .RESP_W(RESP_W),
    .IOWR_CODE(IOWR_CODE), .ABORT_CODE(ABORT_CODE),
    .DEFER_CODE(DEFER_CODE), .PORT_ADDR(PORT_ADDR)
  ) u_match (
    .smp_type(smp_type), .smp_addr(smp_addr), .smp_resp(smp_resp),
    .port_wr(port_wr), .resp_any(resp_any), .br_hit(br_hit)
  );

  bts_level_fsm #(.POST_N(POST_N)) u_fsm (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .port_wr(port_wr), .resp_any(resp_any), .br_hit(br_hit),
    .level(level), .lvl_store(lvl_store), .match_ev(match_ev)
  );

  bts_store_qual u_qual (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .smp_valid(smp_valid), .lvl_store(lvl_store), .cust_qual(cust_qual),
    .store_en(store_en)
  );

  bts_match_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .inc(match_ev), .cnt(match_cnt)
  );

  assign level_o = level;

  p_match_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |-> (store_en && level == LV_HUNT));

endmodule

// File: tb/bus_trig_seq_bench.sv
module bus_trig_seq_bench;
  localparam logic [3:0]  IOW  = 4'h6;
  localparam logic [3:0]  ABT  = 4'hF;
  localparam logic [3:0]  DEF  = 4'hE;
  localparam logic [3:0]  OTH  = 4'h5;
  localparam logic [15:0] PORT = 16'h0080;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_in = 2'd0;
  logic        smp_valid = 1'b0;
  logic [3:0]  smp_type = '0;
  logic [15:0] smp_addr = '0;
  logic [2:0]  smp_resp = '0;
  logic        cust_qual = 1'b0;
  logic        store_en;
  logic [2:0]  level_o;
  logic [15:0] match_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_trig_seq u_bus_trig_seq (
    .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_in(mode_in),
    .smp_valid(smp_valid), .smp_type(smp_type), .smp_addr(smp_addr),
    .smp_resp(smp_resp), .cust_qual(cust_qual), .store_en(store_en),
    .level_o(level_o), .match_cnt(match_cnt)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one sample, check the same-cycle store strobe and the next level.
  task automatic step(input logic v, input logic [3:0] ty, input logic [15:0] ad,
                      input logic [2:0] rs, input logic cq,
                      input logic exp_st, input int exp_lv, input string tag);
    @(negedge clk);
    smp_valid = v; smp_type = ty; smp_addr = ad; smp_resp = rs; cust_qual = cq;
    #2;
    check({tag, " store"}, int'(store_en), int'(exp_st));
    @(posedge clk);
    #1;
    check({tag, " level"}, int'(level_o), exp_lv);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    smp_valid = 1'b0; mode_we = 1'b1; mode_in = m;
    @(negedge clk);
    mode_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 1'b0; mode_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 level", int'(level_o), 1);
    check("R1 count", int'(match_cnt), 0);
    step(1, OTH, PORT, 0, 1, 0, 1, "R1 nonmatch");
    step(1, IOW, 16'h0081, 0, 0, 0, 1, "R5 wrong port");
    step(1, OTH, PORT, 0, 0, 0, 1, "R5 wrong type");
  endtask

  task automatic t_path_rsp();
    step(1, IOW, PORT, 0, 0, 1, 2, "R5 match");
    check("R5 count", int'(match_cnt), 1);
    step(0, IOW, PORT, 3'b001, 0, 0, 2, "R10 idle branch");
    step(1, OTH, 16'h0010, 0, 0, 0, 2, "R6 no branch");
    step(1, IOW, PORT, 3'b010, 0, 0, 4, "R6 priority resp");
    step(1, OTH, 16'h0, 0, 0, 1, 4, "R7 wait L4");
    step(1, OTH, 16'h0, 3'b001, 0, 0, 5, "R7 adv L4");
    step(1, OTH, 16'h0, 3'b100, 0, 0, 6, "R7 adv L5");
    step(1, OTH, 16'h0, 0, 0, 1, 6, "R7 wait L6");
    step(1, OTH, 16'h0, 3'b011, 0, 0, 7, "R7 adv L6");
    step(0, OTH, 16'h0, 0, 0, 0, 7, "R10 idle tail");
    for (int i = 0; i < 4; i++) step(1, OTH, 16'h0, 0, 0, 1, 7, "R8 tail");
    step(1, OTH, 16'h0, 3'b111, 0, 1, 1, "R8 tail end");
    check("R10 count", int'(match_cnt), 1);
  endtask

  task automatic t_branches();
    step(1, IOW, PORT, 0, 0, 1, 2, "R5 match2");
    step(1, IOW, PORT, 0, 0, 0, 3, "R6 port write");
    step(1, OTH, 16'h0, 0, 0, 1, 3, "R7 wait L3");
    step(1, OTH, 16'h0, 3'b001, 0, 0, 4, "R7 adv L3");
    step(1, OTH, 16'h0, 3'b001, 0, 0, 5, "R7 adv L4b");
    step(1, OTH, 16'h0, 3'b001, 0, 0, 6, "R7 adv L5b");
    step(1, OTH, 16'h0, 3'b001, 0, 0, 7, "R7 adv L6b");
    for (int i = 0; i < 5; i++)
      step(1, OTH, 16'h0, 0, 0, 1, (i == 4) ? 1 : 7, "R8 tail b");
    step(1, IOW, PORT, 0, 0, 1, 2, "R5 match3");
    step(1, ABT, 16'h0, 0, 0, 0, 1, "R6 abort");
    step(1, IOW, PORT, 0, 0, 1, 2, "R5 match4");
    step(1, DEF, 16'h0, 0, 0, 0, 7, "R6 defer");
    for (int i = 0; i < 5; i++)
      step(1, OTH, 16'h0, 0, 0, 1, (i == 4) ? 1 : 7, "R8 tail c");
    check("R5 count4", int'(match_cnt), 4);
  endtask

  task automatic t_modes();
    set_mode(2'd1);
    step(1, OTH, 16'h0, 0, 0, 1, 1, "R3 all");
    step(0, OTH, 16'h0, 0, 1, 0, 1, "R4 invalid");
    set_mode(2'd2);
    step(1, OTH, 16'h0, 0, 1, 1, 1, "R3 custom hit");
    step(1, OTH, 16'h0, 0, 0, 0, 1, "R3 custom miss");
    step(1, IOW, PORT, 0, 0, 1, 2, "R3 custom level");
    step(1, OTH, 16'h0, 0, 1, 1, 2, "R3 custom L2");
    step(1, ABT, 16'h0, 0, 0, 0, 1, "R6 abort2");
    set_mode(2'd3);
    step(1, OTH, 16'h0, 0, 1, 0, 1, "R2 code3");
    set_mode(2'd0);
    step(1, OTH, 16'h0, 0, 1, 0, 1, "R2 none");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_type = IOW; smp_addr = PORT; smp_resp = '0;
      @(negedge clk);
      smp_type = ABT;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    check("R9 saturate", int'(match_cnt), 16'hFFFF);
    step(1, IOW, PORT, 0, 0, 1, 2, "R9 match at max");
    check("R9 hold max", int'(match_cnt), 16'hFFFF);
    do_reset();
    check("R9 reset clear", int'(match_cnt), 0);
    check("R1 level after reset", int'(level_o), 1);
  endtask

  initial begin
    t_reset();
    t_path_rsp();
    t_branches();
    t_modes();
    t_saturate();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule